// File: doc/BRIEF.md
# Modem-Line Automatic Flow Controller

This block automates hardware flow control for one serial channel. It sits between the receive FIFO level, the modem-control settings held by software, and the active-low modem pins. On the receive side it throttles the far end. It raises the selected request pin (RTS or DTR) once the receive FIFO fills to an upper threshold. It lowers the pin again only after the fill level drops below a lower threshold, so the pin does not chatter around a single mark. It also raises an interrupt request when the fill reaches a separate trigger level.

On the transmit side the block watches the selected active-low clear input (CTS or DSR) through a two-stage synchronizer. It produces a transmit-allow level that the transmitter samples before it starts each new character. A character already in flight is always finished, because the transmitter only consults this level at a character start.

A single pair-select bit moves both sides together between the RTS/CTS pair and the DTR/DSR pair. Automatic throttling only acts on a pin that software has already asserted. With automatic control off, each request pin is a plain general-purpose output. All signals are plain level controls; there is no data stream and so no valid/ready handshake.

Top module: `modem_flow_ctl`

## Requirements
- R1: After reset, with both automatic modes off and both software bits clear, rts_n and dtr_n read 1, tx_allow reads 1 and trig_irq reads 0.
- R2: With auto_rx_en = 0, rts_n equals the inverse of sw_rts and dtr_n equals the inverse of sw_dtr, whatever the FIFO level.
- R3: With auto_rx_en = 1 and the selected software bit set, a clock edge that samples rx_level >= thr_hi makes the selected pin read 1 after that edge.
- R4: Under the same enables, the selected pin returns to 0 only after an edge that samples rx_level < thr_lo (and below thr_hi). Levels from thr_lo up to thr_hi - 1 keep the previous pin value.
- R5: Automatic throttling has no effect on a pin whose software bit is clear: that pin reads 1 at any level.
- R6: pair_sel = 0 places rts_n/cts_n under automatic control; pair_sel = 1 places dtr_n/dsr_n under it. The pin that is not selected follows its software bit only.
- R7: trig_irq reads 1 after an edge that sampled auto_rx_en = 1 and rx_level >= trig_lvl, and reads 0 after any other edge.
- R8: With auto_tx_en = 1, tx_allow equals the inverse of the selected clear input (cts_n when pair_sel = 0, dsr_n when pair_sel = 1), delayed by two clock edges of synchronization.
- R9: With auto_tx_en = 0, tx_allow reads 1 regardless of cts_n and dsr_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| thr_hi | input | LVL_W | Upper threshold: throttle at or above |
| thr_lo | input | LVL_W | Lower threshold: release below |
| trig_lvl | input | LVL_W | Interrupt trigger level |
| auto_rx_en | input | 1 | Enable automatic request-pin control |
| auto_tx_en | input | 1 | Enable automatic transmit gating |
| pair_sel | input | 1 | 0 = RTS/CTS pair, 1 = DTR/DSR pair |
| sw_rts | input | 1 | Software RTS request (1 = assert, pin low) |
| sw_dtr | input | 1 | Software DTR request (1 = assert, pin low) |
| cts_n | input | 1 | Active-low clear-to-send pin, asynchronous |
| dsr_n | input | 1 | Active-low data-set-ready pin, asynchronous |
| rts_n | output | 1 | Active-low RTS pin |
| dtr_n | output | 1 | Active-low DTR pin |
| tx_allow | output | 1 | 1 = transmitter may start a new character |
| trig_irq | output | 1 | Receive trigger-level interrupt request |

## Verification
A hysteresis flag that is wrong shows at the selected request pin within one edge of the FIFO level crossing a threshold. It can also hide until the level walks back through the band between thresholds, which is why the sweeps move the level both up and down for every threshold pair. A wrong synchronizer depth or a swapped pair select shows on tx_allow exactly two edges after the clear input moves. A bad trigger compare shows on trig_irq one edge after the level passes trig_lvl.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic {
    PAIR_RTS_CTS = 1'b0,
    PAIR_DTR_DSR = 1'b1
  } pair_e;

  localparam int NUM_PAIRS = 2;
endpackage

// File: rtl/mfc_sync.sv
module mfc_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mfc_req_gate.sv
module mfc_req_gate #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  output logic             hold
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (!en)                  hold_d = 1'b0;
    else if (level >= thr_hi) hold_d = 1'b1;
    else if (level < thr_lo)  hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold = hold_q;
endmodule

// File: rtl/mfc_tx_gate.sv
module mfc_tx_gate
  import mfc_pkg::*;
(
  input  logic  auto_en,
  input  pair_e pair,
  input  logic  cts_s_n,
  input  logic  dsr_s_n,
  output logic  allow
);
  logic clear_n;

  always_comb begin
    clear_n = (pair == PAIR_DTR_DSR) ? dsr_s_n : cts_s_n;
    allow   = !auto_en || !clear_n;
  end
endmodule

// File: rtl/modem_flow_ctl.sv
module modem_flow_ctl
  import mfc_pkg::*;
#(
  parameter int LVL_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  input  logic [LVL_W-1:0] trig_lvl,
  input  logic             auto_rx_en,
  input  logic             auto_tx_en,
  input  logic             pair_sel,
  input  logic             sw_rts,
  input  logic             sw_dtr,
  input  logic             cts_n,
  input  logic             dsr_n,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             tx_allow,
  output logic             trig_irq
);
  pair_e pair;
  logic  sel_sw, auto_act, hold;
  logic  irq_q;
  logic [NUM_PAIRS-1:0] clr_raw, clr_s;
  logic [NUM_PAIRS-1:0] sw_vec, sel_vec, pin_vec;

  assign pair     = pair_e'(pair_sel);
  assign sel_sw   = (pair == PAIR_DTR_DSR) ? sw_dtr : sw_rts;
  assign auto_act = auto_rx_en && sel_sw;

  mfc_req_gate #(.LVL_W(LVL_W)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (auto_act),
    .level  (rx_level),
    .thr_hi (thr_hi),
    .thr_lo (thr_lo),
    .hold   (hold)
  );

  // index 0 = RTS/CTS, index 1 = DTR/DSR
  assign sw_vec  = {sw_dtr, sw_rts};
  assign sel_vec = {pair == PAIR_DTR_DSR, pair == PAIR_RTS_CTS};

  genvar p;
  generate
    for (p = 0; p < NUM_PAIRS; p++) begin : g_pin
      assign pin_vec[p] = !sw_vec[p] || (sel_vec[p] && auto_act && hold);
    end
  endgenerate

  assign rts_n = pin_vec[0];
  assign dtr_n = pin_vec[1];

  assign clr_raw = {dsr_n, cts_n};

  mfc_sync #(.W(NUM_PAIRS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (clr_raw),
    .q     (clr_s)
  );

  mfc_tx_gate u_tx (
    .auto_en (auto_tx_en),
    .pair    (pair),
    .cts_s_n (clr_s[0]),
    .dsr_s_n (clr_s[1]),
    .allow   (tx_allow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= auto_rx_en && (rx_level >= trig_lvl);
  end

  assign trig_irq = irq_q;
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] thr_hi,
  input logic [LVL_W-1:0] thr_lo,
  input logic [LVL_W-1:0] trig_lvl,
  input logic             auto_rx_en,
  input logic             auto_tx_en,
  input logic             pair_sel,
  input logic             sw_rts,
  input logic             sw_dtr,
  input logic             rts_n,
  input logic             dtr_n,
  input logic             tx_allow,
  input logic             trig_irq
);
  a_r2_manual_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rx_en |-> (rts_n == !sw_rts) && (dtr_n == !sw_dtr));

  a_r3_throttle_rts: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rx_en && !pair_sel && sw_rts && rx_level >= thr_hi)
      |=> (!(auto_rx_en && !pair_sel && sw_rts) || rts_n));

  a_r4_release_rts: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rx_en && !pair_sel && sw_rts && rx_level < thr_lo && rx_level < thr_hi)
      |=> (!(auto_rx_en && !pair_sel && sw_rts) || !rts_n));

  a_r5_idle_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rts |-> rts_n) and (!sw_dtr |-> dtr_n));

  a_r6_unselected_dtr: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_sel |-> (dtr_n == !sw_dtr));

  a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rx_en && rx_level >= trig_lvl) |=> trig_irq);

  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(auto_rx_en && rx_level >= trig_lvl) |=> !trig_irq);

  a_r9_tx_free: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_tx_en |-> tx_allow);
endmodule

bind modem_flow_ctl mfc_checker #(.LVL_W(LVL_W)) u_mfc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_level   (rx_level),
  .thr_hi     (thr_hi),
  .thr_lo     (thr_lo),
  .trig_lvl   (trig_lvl),
  .auto_rx_en (auto_rx_en),
  .auto_tx_en (auto_tx_en),
  .pair_sel   (pair_sel),
  .sw_rts     (sw_rts),
  .sw_dtr     (sw_dtr),
  .rts_n      (rts_n),
  .dtr_n      (dtr_n),
  .tx_allow   (tx_allow),
  .trig_irq   (trig_irq)
);

// File: tb/test_modem_flow_ctl.sv
module test_modem_flow_ctl;
  localparam int LVL_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0] rx_level = '0, thr_hi = '0, thr_lo = '0, trig_lvl = '0;
  logic auto_rx_en = 0, auto_tx_en = 0, pair_sel = 0, sw_rts = 0, sw_dtr = 0;
  logic cts_n = 1, dsr_n = 1;
  logic rts_n, dtr_n, tx_allow, trig_irq;

  int total = 0;
  int bad = 0;
  bit mdl_hold = 0;

  always #4 clk = ~clk;

  modem_flow_ctl #(.LVL_W(LVL_W)) i_modem_flow_ctl (
    .clk, .rst_n, .rx_level, .thr_hi, .thr_lo, .trig_lvl,
    .auto_rx_en, .auto_tx_en, .pair_sel, .sw_rts, .sw_dtr,
    .cts_n, .dsr_n, .rts_n, .dtr_n, .tx_allow, .trig_irq
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one edge with current inputs; model updated, outputs sampled 1 ns after
  task automatic tick_rx();
    bit en, sel_sw, irq_exp, rts_exp, dtr_exp;
    sel_sw  = pair_sel ? sw_dtr : sw_rts;
    en      = auto_rx_en && sel_sw;
    irq_exp = auto_rx_en && (int'(rx_level) >= int'(trig_lvl));
    if (!en) mdl_hold = 0;
    else if (int'(rx_level) >= int'(thr_hi)) mdl_hold = 1;
    else if (int'(rx_level) < int'(thr_lo)) mdl_hold = 0;
    @(posedge clk); #1;
    rts_exp = !sw_rts || (!pair_sel && en && mdl_hold);
    dtr_exp = !sw_dtr || ( pair_sel && en && mdl_hold);
    chk(rts_n, rts_exp, "R3/R4/R6 rts_n");
    chk(dtr_n, dtr_exp, "R3/R4/R6 dtr_n");
    chk(trig_irq, irq_exp, "R7 trig_irq");
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(rts_n, 1, "R1 rts_n");
    chk(dtr_n, 1, "R1 dtr_n");
    chk(tx_allow, 1, "R1 tx_allow");
    chk(trig_irq, 0, "R1 trig_irq");
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R2 manual mode: every software/select combination at a full level
    rx_level = 7'd60; thr_hi = 7'd4; thr_lo = 7'd2; trig_lvl = 7'd1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      sw_rts = c[0]; sw_dtr = c[1]; pair_sel = c[2];
      @(posedge clk); #1;
      chk(rts_n, !sw_rts, "R2 rts_n");
      chk(dtr_n, !sw_dtr, "R2 dtr_n");
      chk(trig_irq, 0, "R7 irq off");
    end

    // R5: auto on but software bit clear, level above threshold
    @(negedge clk);
    auto_rx_en = 1; sw_rts = 0; sw_dtr = 0; pair_sel = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(rts_n, 1, "R5 rts_n");
    chk(dtr_n, 1, "R5 dtr_n");

    // R3/R4/R6/R7 sweep: both pairs, all threshold pairs, level up then down
    for (int pr = 0; pr < 2; pr++) begin
      for (int hi = 1; hi <= 6; hi++) begin
        for (int lo = 0; lo <= hi; lo++) begin
          @(negedge clk);
          auto_rx_en = 0; pair_sel = pr[0]; sw_rts = 1; sw_dtr = 1;
          thr_hi = 7'(hi); thr_lo = 7'(lo); trig_lvl = 7'(hi - 1);
          rx_level = '0;
          tick_rx();
          @(negedge clk); auto_rx_en = 1;
          for (int v = 0; v <= 8; v++) begin
            @(negedge clk); rx_level = 7'(v);
            tick_rx();
          end
          for (int v = 8; v >= 0; v--) begin
            @(negedge clk); rx_level = 7'(v);
            tick_rx();
          end
        end
      end
    end

    // R5 again: throttled pin dropped by software, then re-asserted
    @(negedge clk);
    pair_sel = 0; sw_rts = 1; thr_hi = 7'd5; thr_lo = 7'd2; rx_level = 7'd9;
    tick_rx();
    @(negedge clk); sw_rts = 0; rx_level = 7'd3;
    tick_rx();
    @(negedge clk); sw_rts = 1;
    tick_rx();
    chk(rts_n, 0, "R5 re-assert releases");

    // R8/R9: transmit gating, every enable/pair/input combination
    @(negedge clk); auto_rx_en = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      auto_tx_en = c[0]; pair_sel = c[1]; cts_n = c[2]; dsr_n = c[3];
      repeat (3) @(posedge clk);
      #1;
      if (!auto_tx_en) chk(tx_allow, 1, "R9 tx_allow");
      else chk(tx_allow, pair_sel ? !dsr_n : !cts_n, "R8 tx_allow");
    end

    // R8 latency: two edges from pin change to tx_allow
    for (int pr = 0; pr < 2; pr++) begin
      @(negedge clk);
      auto_tx_en = 1; pair_sel = pr[0]; cts_n = 0; dsr_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (pr == 0) cts_n = 1; else dsr_n = 1;
      @(posedge clk); #1;
      chk(tx_allow, 1, "R8 one edge: still allowed");
      @(posedge clk); #1;
      chk(tx_allow, 0, "R8 two edges: stopped");
      @(negedge clk);
      if (pr == 0) cts_n = 0; else dsr_n = 0;
      @(posedge clk); #1;
      chk(tx_allow, 0, "R8 one edge: still stopped");
      @(posedge clk); #1;
      chk(tx_allow, 1, "R8 two edges: resumed");
      // the unselected input has no effect
      @(negedge clk);
      if (pr == 0) dsr_n = 1; else cts_n = 1;
      repeat (3) @(posedge clk);
      #1;
      chk(tx_allow, 1, "R8 unselected input ignored");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule